// File: doc/BRIEF.md
# Power-on configuration strap sampler for a 10/100 transceiver digital core

This block sets up the digital core of a 10/100 Ethernet transceiver from the levels on a few board-strapped pins. While the hardware reset is held, three shared pins are read as a 3-bit mode strap and one dedicated pin is read as an interface-select strap. On the clock edge where reset goes inactive, the block decodes these values into default contents for the basic-control, advertisement and special-modes register fields. From then on, the three shared pins are driven outputs carrying their normal receive-side data.

Software can read and write the fields through a simple management port (address, write strobe, write data, combinational read data). A soft reset can come from a control-register bit or from a dedicated input. A soft reset reloads the speed, duplex, autonegotiation and power-down fields from the stored mode field and does not look at the pins again. Because of this, a strapped power-down mode can only be left by rewriting the mode field and then issuing a soft reset.

Top module: `strap_cfg_loader`

## Requirements
- R1: While `rstN` is low, `padOe` is 0. `padOe` goes to 1 on the first clock edge with `rstN` high, and it can then be observed after that edge. With `padOe` high, `padOut` = {`colCrsDv`, `rxData[1]`, `rxData[0]`}.
- R2: The control register is at address 0. Its fields are speed at bit 13, autoneg at bit 12, power-down at bit 11 and duplex at bit 8. They are loaded from the mode strap as {speed,autoneg,powerdown,duplex}:
  - 000 gives 0000, 001 gives 0001, 010 gives 1000 and 011 gives 1001.
  - 100 and 101 give 1100.
  - 110 gives 1110.
  - 111 gives 1100, which keeps the reset values speed=1 and duplex=0.
- R3: The advertisement field is bits [8:5] of address 4. It loads 0100 for modes 100 and 101 and 1111 for mode 111. Every other mode keeps its reset value 0001.
- R4: The special-modes register is at address 18. It holds the captured mode in bits [7:5] and the interface-select strap in bit 14 (0 = MII, 1 = RMII). Bit 14 is also driven on `ifaceRmii`.
- R5: A soft reset comes from a write to address 0 with bit 15 set, or from a one-cycle `softRstIn` pulse. It reloads the four control fields from the R2 decode of the stored mode field, not from the pins. It takes precedence over the other bits of the same write, and bit 15 always reads 0.
- R6: A write to the mode field at address 18 changes only the stored value, which reads back at once. The control fields and the `repeaterMode` and `crsOnTx` outputs stay unchanged until the next soft reset.
- R7: When the applied mode is 110, `powerDown` is 1 and writes to bit 11 are ignored. The block leaves power-down only after the stored mode is rewritten and a soft reset follows.
- R8: `repeaterMode` is 1 exactly when the applied mode is 101. `crsOnTx` is 1 when the duplex field is 0 and `repeaterMode` is 0.
- R9: Outside power-down, a write to address 0 without bit 15 stores bits 13, 12, 11 and 8 directly. A write to address 4 stores bits [8:5].
- R10: The straps pass through a two-flop synchronizer. A pin change made in the same cycle as reset release is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Hardware reset, active low, sampled on clk |
| softRstIn | input | 1 | Soft reset request pulse |
| padIn | input | 3 | Shared pin levels read as the mode strap |
| selPadIn | input | 1 | Interface-select strap pin |
| rxData | input | 2 | Receive data bits to drive onto the shared pins |
| colCrsDv | input | 1 | Collision / carrier-valid signal for the third shared pin |
| padOut | output | 3 | Data driven onto the shared pins |
| padOe | output | 1 | Output enable of the shared pins |
| mgmtAddr | input | 5 | Management register address |
| mgmtWr | input | 1 | Management write strobe |
| mgmtWrData | input | 16 | Management write data |
| mgmtRdData | output | 16 | Management read data for mgmtAddr |
| speed100 | output | 1 | Speed field (1 = 100 Mb) |
| fullDuplex | output | 1 | Duplex field |
| anegEnable | output | 1 | Autonegotiation enable field |
| powerDown | output | 1 | Power-down field |
| repeaterMode | output | 1 | Repeater behaviour selected |
| crsOnTx | output | 1 | Carrier sense also asserted during transmit |
| ifaceRmii | output | 1 | Captured interface select (1 = RMII) |

## Verification
The bench runs all eight mode values against both interface-select levels. In each run the pins change at the release edge, which separates a correct synchronized capture from one that takes the late value. A second sweep rewrites the stored mode to each of the eight values and then soft-resets, alternating between the register bit and the input pin. Wrong pin values are presented throughout this sweep, so it shows whether soft reset decodes the stored field or re-reads the pins, and whether a mode write alone disturbs anything. Directed sequences cover entering and leaving power-down, ignored power-down writes, plain field writes and the pad multiplexer.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int MODE_W = 3;
  localparam int ADV_W = 4;

  localparam int BIT_SOFT = 15;
  localparam int BIT_SPEED = 13;
  localparam int BIT_ANEG = 12;
  localparam int BIT_PDOWN = 11;
  localparam int BIT_DUPLEX = 8;
  localparam int ADV_LSB = 5;
  localparam int BIT_RMII = 14;
  localparam int MODE_LSB = 5;

  typedef logic [MODE_W-1:0] mode_t;

  typedef enum logic [MODE_W-1:0] {
    MODE_10_HALF   = 3'b000,
    MODE_10_FULL   = 3'b001,
    MODE_100_HALF  = 3'b010,
    MODE_100_FULL  = 3'b011,
    MODE_ADV_HALF  = 3'b100,
    MODE_REPEATER  = 3'b101,
    MODE_PDOWN     = 3'b110,
    MODE_ALL       = 3'b111
  } modeSel_e;

  typedef struct packed {
    logic speed;
    logic aneg;
    logic pdown;
    logic duplex;
  } ctrl_t;

  typedef struct packed {
    ctrl_t             ctrl;
    logic              advLoad;
    logic [ADV_W-1:0]  adv;
  } decode_t;

  typedef struct packed {
    logic capture;
    logic softLoad;
    logic wrCtrl;
    logic wrAdv;
    logic wrSpecial;
  } strobe_t;

  function automatic decode_t decodeMode(input mode_t m, input ctrl_t rstVal);
    decode_t d;
    d.ctrl    = rstVal;
    d.advLoad = 1'b0;
    d.adv     = '0;
    case (modeSel_e'(m))
      MODE_10_HALF:  d.ctrl = '{speed: 1'b0, aneg: 1'b0, pdown: 1'b0, duplex: 1'b0};
      MODE_10_FULL:  d.ctrl = '{speed: 1'b0, aneg: 1'b0, pdown: 1'b0, duplex: 1'b1};
      MODE_100_HALF: d.ctrl = '{speed: 1'b1, aneg: 1'b0, pdown: 1'b0, duplex: 1'b0};
      MODE_100_FULL: d.ctrl = '{speed: 1'b1, aneg: 1'b0, pdown: 1'b0, duplex: 1'b1};
      MODE_ADV_HALF, MODE_REPEATER: begin
        d.ctrl    = '{speed: 1'b1, aneg: 1'b1, pdown: 1'b0, duplex: 1'b0};
        d.advLoad = 1'b1;
        d.adv     = 4'b0100;
      end
      MODE_PDOWN: d.ctrl.pdown = 1'b1;
      MODE_ALL: begin
        d.ctrl.aneg  = 1'b1;
        d.ctrl.pdown = 1'b0;
        d.advLoad    = 1'b1;
        d.adv        = 4'b1111;
      end
      default: d.ctrl = rstVal;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 5'd0,
  parameter logic [ADDR_W-1:0] ADDR_ADV = 5'd4,
  parameter logic [ADDR_W-1:0] ADDR_SPECIAL = 5'd18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRstIn,
  input  logic [ADDR_W-1:0] mgmtAddr,
  input  logic              mgmtWr,
  input  logic              softBit,
  output strobe_t           stb
);
  logic inReset;
  logic active;

  // Hardware reset is sampled on the clock; inReset marks the held phase.
  always_ff @(posedge clk) begin
    if (!rstN) inReset <= 1'b1;
    else       inReset <= 1'b0;
  end

  assign active = rstN && !inReset;

  always_comb begin
    stb           = '0;
    stb.capture   = rstN && inReset;
    stb.wrCtrl    = active && mgmtWr && (mgmtAddr == ADDR_CTRL);
    stb.wrAdv     = active && mgmtWr && (mgmtAddr == ADDR_ADV);
    stb.wrSpecial = active && mgmtWr && (mgmtAddr == ADDR_SPECIAL);
    stb.softLoad  = active && (softRstIn || (stb.wrCtrl && softBit));
  end

  // R1
  capture_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> !stb.capture);
endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 5'd0,
  parameter logic [ADDR_W-1:0] ADDR_ADV = 5'd4,
  parameter logic [ADDR_W-1:0] ADDR_SPECIAL = 5'd18,
  parameter logic [3:0] CTRL_RST = 4'b1100,
  parameter logic [ADV_W-1:0] ADV_RST = 4'b0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [MODE_W-1:0]  padIn,
  input  logic               selPadIn,
  input  logic [MODE_W-2:0]  rxData,
  input  logic               colCrsDv,
  output logic [MODE_W-1:0]  padOut,
  output logic               padOe,
  input  logic [ADDR_W-1:0]  mgmtAddr,
  input  logic [DATA_W-1:0]  mgmtWrData,
  output logic [DATA_W-1:0]  mgmtRdData,
  output logic               speed100,
  output logic               fullDuplex,
  output logic               anegEnable,
  output logic               powerDown,
  output logic               repeaterMode,
  output logic               crsOnTx,
  output logic               ifaceRmii
);
  localparam int SYNC_W = MODE_W + 1;
  localparam ctrl_t CTRL_DEFAULT = ctrl_t'(CTRL_RST);

  logic [SYNC_W-1:0] syncA;
  logic [SYNC_W-1:0] syncB;
  ctrl_t             ctrl;
  logic [ADV_W-1:0]  adv;
  mode_t             storedMode;
  mode_t             appliedMode;
  logic              rmii;
  decode_t           strapDec;
  decode_t           storedDec;
  logic              pdLocked;
  logic [MODE_W-1:0] dataFn;
  logic              unusedBits;

  // Two-flop synchronizer, free running so it settles while reset is held.
  always_ff @(posedge clk) begin
    syncA <= {selPadIn, padIn};
    syncB <= syncA;
  end

  always_comb begin
    strapDec  = decodeMode(syncB[MODE_W-1:0], CTRL_DEFAULT);
    storedDec = decodeMode(storedMode, CTRL_DEFAULT);
  end

  assign pdLocked = (appliedMode == MODE_PDOWN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl        <= CTRL_DEFAULT;
      adv         <= ADV_RST;
      storedMode  <= '0;
      appliedMode <= '0;
      rmii        <= 1'b0;
      padOe       <= 1'b0;
    end else if (stb.capture) begin
      ctrl        <= strapDec.ctrl;
      if (strapDec.advLoad) adv <= strapDec.adv;
      storedMode  <= syncB[MODE_W-1:0];
      appliedMode <= syncB[MODE_W-1:0];
      rmii        <= syncB[MODE_W];
      padOe       <= 1'b1;
    end else begin
      if (stb.softLoad) begin
        ctrl        <= storedDec.ctrl;
        appliedMode <= storedMode;
      end else if (stb.wrCtrl) begin
        ctrl.speed  <= mgmtWrData[BIT_SPEED];
        ctrl.aneg   <= mgmtWrData[BIT_ANEG];
        ctrl.duplex <= mgmtWrData[BIT_DUPLEX];
        if (!pdLocked) ctrl.pdown <= mgmtWrData[BIT_PDOWN];
      end
      if (stb.wrAdv)     adv        <= mgmtWrData[ADV_LSB +: ADV_W];
      if (stb.wrSpecial) storedMode <= mgmtWrData[MODE_LSB +: MODE_W];
    end
  end

  // Shared pins: data functions once released.
  assign dataFn = {colCrsDv, rxData};
  for (genvar i = 0; i < MODE_W; i++) begin : g_pad
    assign padOut[i] = padOe & dataFn[i];
  end

  always_comb begin
    mgmtRdData = '0;
    if (mgmtAddr == ADDR_CTRL) begin
      mgmtRdData[BIT_SPEED]  = ctrl.speed;
      mgmtRdData[BIT_ANEG]   = ctrl.aneg;
      mgmtRdData[BIT_PDOWN]  = ctrl.pdown;
      mgmtRdData[BIT_DUPLEX] = ctrl.duplex;
    end else if (mgmtAddr == ADDR_ADV) begin
      mgmtRdData[ADV_LSB +: ADV_W] = adv;
    end else if (mgmtAddr == ADDR_SPECIAL) begin
      mgmtRdData[BIT_RMII] = rmii;
      mgmtRdData[MODE_LSB +: MODE_W] = storedMode;
    end
  end

  assign speed100     = ctrl.speed;
  assign fullDuplex   = ctrl.duplex;
  assign anegEnable   = ctrl.aneg;
  assign powerDown    = ctrl.pdown;
  assign repeaterMode = (appliedMode == MODE_REPEATER);
  assign crsOnTx      = !ctrl.duplex && !repeaterMode;
  assign ifaceRmii    = rmii;

  assign unusedBits = ^{mgmtWrData, storedDec.advLoad, storedDec.adv};

  // R1
  pad_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(padOe) |-> $past(stb.capture));

  // R5
  soft_from_stored_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.softLoad |=> (powerDown == ($past(storedMode) == MODE_PDOWN)));

  // R6
  mode_write_inert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSpecial && !stb.softLoad && !stb.wrCtrl && !stb.capture)
      |=> ($stable(appliedMode) && $stable(ctrl)));

  // R7
  pdown_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdLocked && !stb.softLoad && !stb.capture) |=> powerDown);
endmodule

// File: rtl/strap_cfg_loader.sv
module strap_cfg_loader
  import strap_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 5'd0,
  parameter logic [ADDR_W-1:0] ADDR_ADV = 5'd4,
  parameter logic [ADDR_W-1:0] ADDR_SPECIAL = 5'd18,
  parameter logic [3:0] CTRL_RST = 4'b1100,
  parameter logic [3:0] ADV_RST = 4'b0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRstIn,
  input  logic [2:0]        padIn,
  input  logic              selPadIn,
  input  logic [1:0]        rxData,
  input  logic              colCrsDv,
  output logic [2:0]        padOut,
  output logic              padOe,
  input  logic [ADDR_W-1:0] mgmtAddr,
  input  logic              mgmtWr,
  input  logic [DATA_W-1:0] mgmtWrData,
  output logic [DATA_W-1:0] mgmtRdData,
  output logic              speed100,
  output logic              fullDuplex,
  output logic              anegEnable,
  output logic              powerDown,
  output logic              repeaterMode,
  output logic              crsOnTx,
  output logic              ifaceRmii
);
  strobe_t stb;

  strap_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_ADV(ADDR_ADV), .ADDR_SPECIAL(ADDR_SPECIAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .softRstIn(softRstIn), .mgmtAddr(mgmtAddr),
    .mgmtWr(mgmtWr), .softBit(mgmtWrData[BIT_SOFT]), .stb(stb)
  );

  strap_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_ADV(ADDR_ADV),
    .ADDR_SPECIAL(ADDR_SPECIAL), .CTRL_RST(CTRL_RST), .ADV_RST(ADV_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .padIn(padIn), .selPadIn(selPadIn),
    .rxData(rxData), .colCrsDv(colCrsDv), .padOut(padOut), .padOe(padOe),
    .mgmtAddr(mgmtAddr), .mgmtWrData(mgmtWrData), .mgmtRdData(mgmtRdData),
    .speed100(speed100), .fullDuplex(fullDuplex), .anegEnable(anegEnable),
    .powerDown(powerDown), .repeaterMode(repeaterMode), .crsOnTx(crsOnTx),
    .ifaceRmii(ifaceRmii)
  );
endmodule

// File: tb/sim_strap_cfg_loader.sv
module sim_strap_cfg_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRstIn = 1'b0;
  logic [2:0]  padIn = '0;
  logic        selPadIn = 1'b0;
  logic [1:0]  rxData = '0;
  logic        colCrsDv = 1'b0;
  logic [2:0]  padOut;
  logic        padOe;
  logic [4:0]  mgmtAddr = '0;
  logic        mgmtWr = 1'b0;
  logic [15:0] mgmtWrData = '0;
  logic [15:0] mgmtRdData;
  logic speed100, fullDuplex, anegEnable, powerDown, repeaterMode, crsOnTx, ifaceRmii;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  strap_cfg_loader u0 (
    .clk(clk), .rstN(rstN), .softRstIn(softRstIn), .padIn(padIn), .selPadIn(selPadIn),
    .rxData(rxData), .colCrsDv(colCrsDv), .padOut(padOut), .padOe(padOe),
    .mgmtAddr(mgmtAddr), .mgmtWr(mgmtWr), .mgmtWrData(mgmtWrData), .mgmtRdData(mgmtRdData),
    .speed100(speed100), .fullDuplex(fullDuplex), .anegEnable(anegEnable),
    .powerDown(powerDown), .repeaterMode(repeaterMode), .crsOnTx(crsOnTx),
    .ifaceRmii(ifaceRmii)
  );

  // {speed, aneg, pdown, duplex}; reset values speed=1 aneg=1 duplex=0
  function automatic logic [3:0] expCtrl(input logic [2:0] m);
    if (!m[2])      return {m[1], 1'b0, 1'b0, m[0]};
    else if (!m[1]) return 4'b1100;
    else if (!m[0]) return 4'b1110;
    else            return 4'b1100;
  endfunction

  function automatic logic [3:0] expAdv(input logic [2:0] m);
    if (m[2] && !m[1]) return 4'b0100;
    else if (m == 3'd7) return 4'b1111;
    else return 4'b0001;
  endfunction

  function automatic logic [15:0] ctrlWord(input logic [3:0] c);
    return {2'b00, c[3], c[2], c[1], 2'b00, c[0], 8'h00};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    mgmtAddr = a;
    #1;
    v = mgmtRdData;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmtAddr = a; mgmtWrData = d; mgmtWr = 1'b1;
    @(negedge clk);
    mgmtWr = 1'b0; mgmtWrData = '0;
  endtask

  task automatic pinSoft();
    @(negedge clk); softRstIn = 1'b1;
    @(negedge clk); softRstIn = 1'b0;
  endtask

  // Straps held during reset, then altered at the release edge (R10)
  task automatic hwReset(input logic [2:0] m, input logic sel);
    @(negedge clk);
    rstN = 1'b0; padIn = m; selPadIn = sel;
    repeat (4) @(negedge clk);
    chk("R1", "padOe in reset", {15'd0, padOe}, 16'd0);
    rstN = 1'b1; padIn = ~m; selPadIn = ~sel;
    @(negedge clk);
    chk("R1", "padOe after release", {15'd0, padOe}, 16'd1);
  endtask

  task automatic checkState(input string req, input logic [2:0] applied, input logic [2:0] stored,
                            input logic [3:0] c, input logic [3:0] a, input logic sel);
    logic [15:0] v;
    rd(5'd0, v);  chk(req, "ctrl reg", v, ctrlWord(c));
    rd(5'd4, v);  chk(req, "adv reg", v, {7'd0, a, 5'd0});
    rd(5'd18, v); chk(req, "special reg", v, {1'b0, sel, 6'd0, stored, 5'd0});
    chk(req, "powerDown", {15'd0, powerDown}, {15'd0, c[1]});
    chk("R8", "repeaterMode", {15'd0, repeaterMode}, {15'd0, applied == 3'd5});
    chk("R8", "crsOnTx", {15'd0, crsOnTx}, {15'd0, !c[0] && applied != 3'd5});
    chk("R4", "ifaceRmii", {15'd0, ifaceRmii}, {15'd0, sel});
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [2:0] cur;

    // R2 R3 R4 R10: every strap combination, late pin change ignored
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 2; s++) begin
        hwReset(3'(m), 1'(s));
        checkState("R2", 3'(m), 3'(m), expCtrl(3'(m)), expAdv(3'(m)), 1'(s));
      end
    end

    // R1 pad multiplexer
    rxData = 2'b10; colCrsDv = 1'b1; #1;
    chk("R1", "padOut", {13'd0, padOut}, 16'h0006);
    rxData = 2'b01; colCrsDv = 1'b0; #1;
    chk("R1", "padOut", {13'd0, padOut}, 16'h0001);

    // R5 R6: rewrite stored mode, soft reset from stored field
    hwReset(3'd7, 1'b1);
    cur = 3'd7;
    padIn = 3'd2;
    for (int n = 0; n < 8; n++) begin
      wr(5'd18, 16'(n) << 5);
      checkState("R6", cur, 3'(n), expCtrl(cur), 4'b1111, 1'b1);
      if (n % 2 == 0) wr(5'd0, 16'hB100);
      else pinSoft();
      cur = 3'(n);
      checkState("R5", cur, cur, expCtrl(cur), 4'b1111, 1'b1);
    end

    // R9: plain field writes outside power-down
    hwReset(3'd0, 1'b0);
    wr(5'd0, 16'h3100);
    rd(5'd0, v); chk("R9", "ctrl write", v, 16'h3100);
    wr(5'd0, 16'h0800);
    chk("R9", "pdown write", {15'd0, powerDown}, 16'd1);
    wr(5'd4, 16'h0140);
    rd(5'd4, v); chk("R9", "adv write", v, 16'h0140);

    // R7: strapped power-down
    hwReset(3'd6, 1'b0);
    wr(5'd0, 16'h0000);
    rd(5'd0, v); chk("R7", "pdown write ignored", v, 16'h0800);
    chk("R7", "powerDown held", {15'd0, powerDown}, 16'd1);
    pinSoft();
    rd(5'd0, v); chk("R7", "soft reset without rewrite", v, ctrlWord(expCtrl(3'd6)));
    wr(5'd18, 16'(3) << 5);
    chk("R7", "rewrite only", {15'd0, powerDown}, 16'd1);
    wr(5'd0, 16'h8000);
    rd(5'd0, v); chk("R7", "left power-down", v, ctrlWord(expCtrl(3'd3)));
    chk("R5", "soft bit reads 0", {15'd0, v[15]}, 16'd0);
    chk("R7", "powerDown cleared", {15'd0, powerDown}, 16'd0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule